// File: doc/BRIEF.md
# Multimode Prescaled Timer

A single timer channel built around an 8-bit down counter and a prescaler whose division ratio is chosen from a fixed set. A 4-bit control value picks one of four behaviours: stopped, delay (count prescaled ticks of the timer clock), event count (count active edges of an external input), or pulse-width measurement (count prescaled ticks only while the external input sits at its active level). Each time the counter passes through 1, it reloads from a reload register, raises a one-cycle timeout strobe for an interrupt controller, and flips a square-wave output. One output period therefore spans two timeouts.

The timer clock is modelled as a clock enable (`tickEn`) in the system clock domain. Register writes take effect on the system clock whatever `tickEn` is doing. Software sets the control value and the reload value, and reads back the control value and the live counter. Any write to the control value clears the square-wave output and restarts the prescaler. A build parameter can remove the event and pulse-width modes, which gives a delay-only variant.

Top module: `ptimer_chan`

## Requirements
- R1: After reset the control readback is 0, the counter readback is 0, `toggleOut` is 0 and `timeoutPulse` is 0.
- R2: With control value 0 the timer is stopped. `tickEn` and `evIn` leave the counter unchanged and no timeout is produced.
- R3: A data write while the control value is 0 loads both the reload register and the counter. The counter readback shows the written value on the next cycle.
- R4: A data write while the timer runs changes only the reload register. The counter keeps counting, and the next reload uses the new value.
- R5: Control values 1 to 7 select delay mode with prescale 4, 10, 16, 50, 64, 100 and 200 respectively. The counter decrements once per that many `tickEn` cycles.
- R6: A decrement that finds the counter at 1 reloads the counter from the reload register and raises `timeoutPulse` for exactly one cycle, in the cycle after that decrement.
- R7: `toggleOut` inverts on every timeout.
- R8: A control write forces `toggleOut` to 0, restarts the prescaler from zero and suppresses any decrement in that cycle.
- R9: Control value 8 selects event-count mode. Each rising edge of `evIn` decrements the counter, and `tickEn` has no effect.
- R10: Control values 9 to 15 select pulse-width mode with the prescales of values 1 to 7. Prescaled counting advances only while `evIn` is high.
- R11: A reload value of 0 gives a period of 256 decrements. The counter wraps from 0 to 255 and times out on reaching 1.
- R12: The control readback returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer clock enable, one pulse per timer clock cycle |
| ctrlWe | input | 1 | Control write strobe |
| ctrlWdata | input | 4 | Control value to write (mode and prescale select) |
| dataWe | input | 1 | Data/reload write strobe |
| dataWdata | input | 8 | Reload value to write |
| evIn | input | 1 | External event / gate input (asynchronous, synchronised inside) |
| ctrlRdata | output | 4 | Control readback |
| countValue | output | 8 | Live counter readback |
| toggleOut | output | 1 | Square-wave output, inverts on each timeout |
| timeoutPulse | output | 1 | One-cycle strobe per timeout |

## Verification
The bench counts ticks right up to each prescale boundary. A design that used an off-by-one divisor, or that missed a prescaler restart after a control write, would decrement one tick early or late. It loads a reload value of 0 and walks all 256 event edges, which catches a counter that stops at 0 or times out at the wrong point. It writes the reload register mid-count, so a design that also reloaded the counter shows the wrong readback. It sends `tickEn` pulses into event mode, and into pulse-width mode while the gate is low, to expose a timer that counts when it should hold.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int PRE_W = 8;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'd0,
    MODE_DELAY = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_PULSE = 2'd3
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic decr;     // one counting step
    logic clrOut;   // force square wave low
    logic loadCnt;  // load counter from write data
    logic loadRld;  // load reload register from write data
  } dpStrobeT;

  function automatic logic [PRE_W-1:0] preDivisor(input logic [2:0] sel);
    logic [PRE_W-1:0] d;
    case (sel)
      3'd1:    d = 8'd4;
      3'd2:    d = 8'd10;
      3'd3:    d = 8'd16;
      3'd4:    d = 8'd50;
      3'd5:    d = 8'd64;
      3'd6:    d = 8'd100;
      3'd7:    d = 8'd200;
      default: d = 8'd4;
    endcase
    return d;
  endfunction

  function automatic modeT decodeMode(input logic [3:0] c, input logic extModes);
    modeT m;
    if (c == 4'd0)          m = MODE_STOP;
    else if (!c[3])         m = MODE_DELAY;
    else if (!extModes)     m = MODE_STOP;
    else if (c[2:0] == 3'd0) m = MODE_EVENT;
    else                    m = MODE_PULSE;
    return m;
  endfunction

endpackage

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter bit ACTIVE_HIGH   = 1'b1,
  parameter bit HAS_EXT_MODES = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       ctrlWe,
  input  logic [3:0] ctrlWdata,
  input  logic       dataWe,
  input  logic       evIn,
  output logic [3:0] ctrlRdata,
  output dpStrobeT   strb
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [3:0]             ctrlReg;
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   evPrev;
  logic                   lvlNow;
  logic                   lvlPrev;
  logic                   evEdge;
  logic [PRE_W-1:0]       preCnt;
  logic [PRE_W-1:0]       preLast;
  logic                   preGate;
  logic                   preTc;
  modeT                   mode;

  // control register
  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end
  assign ctrlRdata = ctrlReg;

  // input synchroniser and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '0;
      evPrev  <= 1'b0;
    end else begin
      syncReg <= {syncReg[TOP-1:0], evIn};
      evPrev  <= syncReg[TOP];
    end
  end

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign lvlNow  = syncReg[TOP];
      assign lvlPrev = evPrev;
    end else begin : g_pol_low
      assign lvlNow  = ~syncReg[TOP];
      assign lvlPrev = ~evPrev;
    end
  endgenerate

  assign evEdge = lvlNow & ~lvlPrev;

  assign mode    = decodeMode(ctrlReg, HAS_EXT_MODES);
  assign preLast = PRE_W'(preDivisor(ctrlReg[2:0]) - 8'd1);
  assign preGate = (mode == MODE_DELAY) || ((mode == MODE_PULSE) && lvlNow);
  assign preTc   = preGate && tickEn && (preCnt == preLast);

  // prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctrlWe || (mode == MODE_STOP) || (mode == MODE_EVENT)) begin
      preCnt <= '0;
    end else if (preGate && tickEn) begin
      preCnt <= preTc ? '0 : preCnt + 8'd1;
    end
  end

  always_comb begin
    strb.clrOut  = ctrlWe;
    strb.decr    = !ctrlWe && ((mode == MODE_EVENT) ? evEdge : preTc);
    strb.loadRld = dataWe;
    strb.loadCnt = dataWe && (mode == MODE_STOP);
  end

endmodule

// File: rtl/ptimer_dp.sv
module ptimer_dp
  import ptimer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strb,
  input  logic [CNT_W-1:0] dataWdata,
  output logic [CNT_W-1:0] countValue,
  output logic             toggleOut,
  output logic             timeoutPulse
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] cntReg;
  logic             atEnd;

  assign atEnd = strb.decr && (cntReg == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN)             reloadReg <= '0;
    else if (strb.loadRld) reloadReg <= dataWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cntReg <= '0;
    else if (strb.loadCnt) cntReg <= dataWdata;
    else if (atEnd)        cntReg <= reloadReg;
    else if (strb.decr)    cntReg <= cntReg - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleOut    <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= atEnd;
      if (strb.clrOut)  toggleOut <= 1'b0;
      else if (atEnd)   toggleOut <= ~toggleOut;
    end
  end

  assign countValue = cntReg;

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter bit ACTIVE_HIGH   = 1'b1,
  parameter bit HAS_EXT_MODES = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             ctrlWe,
  input  logic [3:0]       ctrlWdata,
  input  logic             dataWe,
  input  logic [CNT_W-1:0] dataWdata,
  input  logic             evIn,
  output logic [3:0]       ctrlRdata,
  output logic [CNT_W-1:0] countValue,
  output logic             toggleOut,
  output logic             timeoutPulse
);

  dpStrobeT strb;

  ptimer_ctrl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .ACTIVE_HIGH  (ACTIVE_HIGH),
    .HAS_EXT_MODES(HAS_EXT_MODES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .dataWe   (dataWe),
    .evIn     (evIn),
    .ctrlRdata(ctrlRdata),
    .strb     (strb)
  );

  ptimer_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dataWdata   (dataWdata),
    .countValue  (countValue),
    .toggleOut   (toggleOut),
    .timeoutPulse(timeoutPulse)
  );

endmodule

// File: rtl/ptimer_chan_chk.sv
module ptimer_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         ctrlWe,
  input logic [3:0]   ctrlWdata,
  input logic         dataWe,
  input logic [3:0]   ctrlRdata,
  input logic [W-1:0] countValue,
  input logic         toggleOut,
  input logic         timeoutPulse
);

  p_stop_freeze_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata == 4'd0 && !dataWe) |=> $stable(countValue));

  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata == 4'd0) |=> !timeoutPulse);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (toggleOut != $past(toggleOut)));

  p_ctrl_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> !toggleOut);

  p_ctrl_readback_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> (ctrlRdata == $past(ctrlWdata)));

endmodule

bind ptimer_chan ptimer_chan_chk #(.W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWe      (ctrlWe),
  .ctrlWdata   (ctrlWdata),
  .dataWe      (dataWe),
  .ctrlRdata   (ctrlRdata),
  .countValue  (countValue),
  .toggleOut   (toggleOut),
  .timeoutPulse(timeoutPulse)
);

// File: tb/ptimer_chan_tb_top.sv
`timescale 1ns/1ps
module ptimer_chan_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       ctrlWe;
  logic [3:0] ctrlWdata;
  logic       dataWe;
  logic [7:0] dataWdata;
  logic       evIn;
  logic [3:0] ctrlRdata;
  logic [7:0] countValue;
  logic       toggleOut;
  logic       timeoutPulse;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ptimer_chan dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .ctrlWe      (ctrlWe),
    .ctrlWdata   (ctrlWdata),
    .dataWe      (dataWe),
    .dataWdata   (dataWdata),
    .evIn        (evIn),
    .ctrlRdata   (ctrlRdata),
    .countValue  (countValue),
    .toggleOut   (toggleOut),
    .timeoutPulse(timeoutPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(posedge clk);
      #1;
    end
    tickEn = 1'b0;
  endtask

  task automatic wrCtrl(input logic [3:0] v);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    @(posedge clk);
    #1;
    ctrlWe = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] v);
    dataWe = 1'b1;
    dataWdata = v;
    @(posedge clk);
    #1;
    dataWe = 1'b0;
  endtask

  task automatic evPulse(input int n);
    for (int i = 0; i < n; i++) begin
      evIn = 1'b1;
      step(3);
      evIn = 1'b0;
      step(3);
    end
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrlRdata, 0);
    check("R1 count", countValue, 0);
    check("R1 out", toggleOut, 0);
    check("R1 timeout", timeoutPulse, 0);
  endtask

  task automatic t_stopped;
    tick(50);
    evPulse(2);
    check("R2 stopped count", countValue, 0);
    wrData(8'd3);
    check("R3 load while stopped", countValue, 3);
    tick(20);
    check("R2 stopped hold", countValue, 3);
  endtask

  task automatic t_delay;
    wrCtrl(4'd1);
    check("R12 ctrl readback", ctrlRdata, 1);
    tick(3);
    check("R5 div4 before", countValue, 3);
    tick(1);
    check("R5 div4 step", countValue, 2);
    tick(4);
    check("R5 div4 second", countValue, 1);
    tick(3);
    check("R6 no early timeout", timeoutPulse, 0);
    tick(1);
    check("R6 timeout pulse", timeoutPulse, 1);
    check("R6 reload", countValue, 3);
    check("R7 out high", toggleOut, 1);
    step(1);
    check("R6 pulse one cycle", timeoutPulse, 0);
    tick(12);
    check("R7 out low again", toggleOut, 0);
  endtask

  task automatic t_runReload;
    wrData(8'd5);
    check("R4 counter kept", countValue, 3);
    tick(12);
    check("R4 new reload used", countValue, 5);
    check("R4 out", toggleOut, 1);
  endtask

  task automatic t_ctrlClear;
    tick(2);
    wrCtrl(4'd1);
    check("R8 out forced low", toggleOut, 0);
    check("R8 count kept", countValue, 5);
    tick(3);
    check("R8 prescaler restarted", countValue, 5);
    tick(1);
    check("R8 step after restart", countValue, 4);
  endtask

  task automatic t_prescale;
    wrCtrl(4'd3);
    tick(15);
    check("R5 div16 before", countValue, 4);
    tick(1);
    check("R5 div16 step", countValue, 3);
    wrCtrl(4'd7);
    tick(199);
    check("R5 div200 before", countValue, 3);
    tick(1);
    check("R5 div200 step", countValue, 2);
  endtask

  task automatic t_event;
    wrCtrl(4'd8);
    tick(30);
    check("R9 tick ignored", countValue, 2);
    evPulse(1);
    check("R9 edge step", countValue, 1);
    evPulse(1);
    check("R9 edge timeout reload", countValue, 5);
    check("R9 out toggled", toggleOut, 1);
  endtask

  task automatic t_pulse;
    wrCtrl(4'd9);
    tick(8);
    check("R10 gate low holds", countValue, 5);
    evIn = 1'b1;
    step(3);
    tick(4);
    check("R10 gate high step", countValue, 4);
    tick(4);
    check("R10 gate high step2", countValue, 3);
    evIn = 1'b0;
    step(3);
    tick(8);
    check("R10 gate low again", countValue, 3);
  endtask

  task automatic t_wrap;
    wrCtrl(4'd0);
    wrData(8'd0);
    check("R11 load zero", countValue, 0);
    wrCtrl(4'd8);
    evPulse(1);
    check("R11 wrap to 255", countValue, 255);
    evPulse(254);
    check("R11 at one", countValue, 1);
    check("R11 no toggle yet", toggleOut, 0);
    evPulse(1);
    check("R11 reload zero", countValue, 0);
    check("R11 toggle after 256", toggleOut, 1);
  endtask

  initial begin
    rstN = 1'b0;
    tickEn = 1'b0;
    ctrlWe = 1'b0;
    ctrlWdata = '0;
    dataWe = 1'b0;
    dataWdata = '0;
    evIn = 1'b0;
    step(4);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_stopped();
    t_delay();
    t_runReload();
    t_ctrlClear();
    t_prescale();
    t_event();
    t_pulse();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule